// File: doc/BRIEF.md
# Image Row Zero-Bias Corrector

This block sits between an image sensor that delivers bytes one row at a time and a small processor bus. A write to its command register starts a capture of a whole frame. Each sensor row starts with a few samples taken from masked dark columns, followed by the image pixels. For each row the engine does three things. It gathers the row into an internal frame buffer. It estimates that row's zero-bias error from the dark samples. It then subtracts that bias from every pixel of the row in place, with the result clamped at zero.

When every row has been corrected, a status register reports that the frame is ready. The processor then reads the corrected pixels over the bus, one byte per read, at an address formed from the row and column. The default geometry is 64 rows of 64 pixels with two dark samples in front of each row. All dimensions and addresses are parameters.

Top module: `zbc_corrector`

## Requirements
- R1: After reset the status register reads 0 and `sen_ready` is low.
- R2: A bus write of exactly 1 to the command address (default 0x9000) starts a capture, and `sen_ready` is high in the next cycle. A write of any other value, or to any other address, starts nothing.
- R3: A row is exactly 2 + 64 = 66 accepted bytes. A byte is accepted only in a cycle with both `sen_valid` and `sen_ready` high. The first two accepted bytes of a row are the dark samples, and the remaining 64 are pixels for columns 0 to 63 in arrival order.
- R4: The row bias is (dark0 + dark1) >> 1. Each stored pixel becomes pixel − bias whenever pixel > bias.
- R5: When pixel ≤ bias, the stored result is 0. It never wraps.
- R6: A read strobe in cycle t gives its data on `bus_rdata` in cycle t+1 only. In every other cycle `bus_rdata` is 0, and a read of an address that maps to nothing returns 0.
- R7: The status register (default 0x9001, bit 0) reads 1 only when the engine is idle and a complete frame has been corrected. It reads 0 from a start until the last row is done.
- R8: The corrected pixel of row r, column c is read at buffer base (default 0x8000) + r*64 + c.
- R9: A start command written while a capture is running is ignored, and the capture in progress completes unchanged.
- R10: `sen_ready` is low while a row's bias is computed and applied. After the last byte of a row, it stays low for at least one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sen_valid | input | 1 | Sensor byte valid |
| sen_data | input | 8 | Sensor byte |
| sen_ready | output | 1 | Engine accepts a sensor byte this cycle |
| bus_rd | input | 1 | One-cycle read strobe |
| bus_wr | input | 1 | One-cycle write strobe |
| bus_addr | input | 16 | Bus address |
| bus_wdata | input | 8 | Bus write data |
| bus_rdata | output | 8 | Read data, valid the cycle after the strobe |

## Verification
Some internal faults would show up only as wrong pixel values at the bus. These are an off-by-one row or column counter, a wrong bias register, or an arithmetic slip in the subtract. Such faults cannot be seen until the frame has finished and been read back, which is thousands of cycles after the fault. A miscounted row length shows up sooner. `sen_ready` stays high or drops at the wrong byte within one row of the fault, and the final status poll then either times out or completes too early. A faulty command decode or busy gating shows up on the next status read or in a frame that never completes.

// File: rtl/zbc_pkg.sv
package zbc_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_GETROW,
      ST_CBIAS,
      ST_FIXBIAS,
      ST_NEXTROW
   } zbc_state_e;

endpackage

// File: rtl/zbc_bias_unit.sv
module zbc_bias_unit #(
   parameter int PIX_W  = 8,
   parameter int DARK_N = 2
) (
   input  logic [DARK_N-1:0][PIX_W-1:0] dark_vec,
   output logic [PIX_W-1:0]             bias_est,
   input  logic [PIX_W-1:0]             pix,
   input  logic [PIX_W-1:0]             bias_use,
   output logic [PIX_W-1:0]             corr
);
   localparam int DARK_SH = (DARK_N > 1) ? $clog2(DARK_N) : 0;
   localparam int SUM_W   = PIX_W + DARK_SH;

   // Bias estimate: mean of the dark samples (power-of-two count)
   generate
      if (DARK_N == 1) begin : g_single
         assign bias_est = dark_vec[0];
      end else begin : g_mean
         logic [SUM_W-1:0] sum;
         always_comb begin
            sum = '0;
            for (int i = 0; i < DARK_N; i++) begin
               sum = sum + SUM_W'(dark_vec[i]);
            end
         end
         assign bias_est = PIX_W'(sum >> DARK_SH);
      end
   endgenerate

   // Clamped subtract
   always_comb begin
      if (pix > bias_use) corr = pix - bias_use;
      else                corr = '0;
   end

endmodule

// File: rtl/zbc_row_ctrl.sv
module zbc_row_ctrl
   import zbc_pkg::*;
#(
   parameter int ROWS   = 64,
   parameter int COLS   = 64,
   parameter int DARK_N = 2,
   parameter int PIX_W  = 8
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          start,
   input  logic                          sen_valid,
   input  logic [PIX_W-1:0]              sen_data,
   output logic                          sen_ready,
   output logic [DARK_N-1:0][PIX_W-1:0]  dark_vec,
   input  logic [PIX_W-1:0]              bias_est,
   output logic [PIX_W-1:0]              bias_use,
   input  logic [PIX_W-1:0]              corr_in,
   output logic [$clog2(ROWS)+$clog2(COLS)-1:0] fix_addr,
   output logic                          mem_we,
   output logic [$clog2(ROWS)+$clog2(COLS)-1:0] mem_addr,
   output logic [PIX_W-1:0]              mem_wdata,
   output logic                          busy,
   output logic                          frame_done
);
   localparam int ROW_AW  = $clog2(ROWS);
   localparam int COL_AW  = $clog2(COLS);
   localparam int COLW    = $clog2(COLS + DARK_N);
   localparam int DK_W    = (DARK_N > 1) ? $clog2(DARK_N) : 1;
   localparam logic [COLW-1:0]   LAST_IN  = COLW'(DARK_N + COLS - 1);
   localparam logic [COLW-1:0]   LAST_PIX = COLW'(COLS - 1);
   localparam logic [COLW-1:0]   DARK_C   = COLW'(DARK_N);
   localparam logic [ROW_AW-1:0] LAST_ROW = ROW_AW'(ROWS - 1);

   zbc_state_e        state_q;
   logic [ROW_AW-1:0] row_q;
   logic [COLW-1:0]   col_q;
   logic [COLW-1:0]   pix_col_w;
   logic              take;

   assign take      = (state_q == ST_GETROW) && sen_valid;
   assign pix_col_w = col_q - DARK_C;
   assign fix_addr  = {row_q, col_q[COL_AW-1:0]};
   assign sen_ready = (state_q == ST_GETROW);
   assign busy      = (state_q != ST_IDLE);
   assign frame_done = (state_q == ST_NEXTROW) && (row_q == LAST_ROW);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         row_q    <= '0;
         col_q    <= '0;
         dark_vec <= '0;
         bias_use <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (start) begin
                  state_q <= ST_GETROW;
                  row_q   <= '0;
                  col_q   <= '0;
               end
            end
            ST_GETROW: begin
               if (take) begin
                  if (col_q < DARK_C) dark_vec[col_q[DK_W-1:0]] <= sen_data;
                  if (col_q == LAST_IN) begin
                     col_q   <= '0;
                     state_q <= ST_CBIAS;
                  end else begin
                     col_q <= col_q + 1'b1;
                  end
               end
            end
            ST_CBIAS: begin
               bias_use <= bias_est;
               state_q  <= ST_FIXBIAS;
            end
            ST_FIXBIAS: begin
               if (col_q == LAST_PIX) begin
                  col_q   <= '0;
                  state_q <= ST_NEXTROW;
               end else begin
                  col_q <= col_q + 1'b1;
               end
            end
            ST_NEXTROW: begin
               if (row_q == LAST_ROW) begin
                  state_q <= ST_IDLE;
               end else begin
                  row_q   <= row_q + 1'b1;
                  state_q <= ST_GETROW;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      mem_we    = 1'b0;
      mem_addr  = fix_addr;
      mem_wdata = corr_in;
      if (take && (col_q >= DARK_C)) begin
         mem_we    = 1'b1;
         mem_addr  = {row_q, pix_col_w[COL_AW-1:0]};
         mem_wdata = sen_data;
      end else if (state_q == ST_FIXBIAS) begin
         mem_we = 1'b1;
      end
   end

endmodule

// File: rtl/zbc_bus_port.sv
module zbc_bus_port #(
   parameter int ADDR_W    = 16,
   parameter int DATA_W    = 8,
   parameter int BUF_AW    = 12,
   parameter int BUF_BYTES = 4096,
   parameter int BUF_BASE  = 'h8000,
   parameter int CMD_ADDR  = 'h9000,
   parameter int STAT_ADDR = 'h9001
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_rd,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic [BUF_AW-1:0] buf_raddr,
   input  logic [DATA_W-1:0] buf_rdata,
   input  logic              stat_bit,
   input  logic              busy,
   output logic              start
);
   localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(BUF_BASE);
   localparam logic [ADDR_W-1:0] SPAN_A = ADDR_W'(BUF_BYTES);
   localparam logic [ADDR_W-1:0] CMD_A  = ADDR_W'(CMD_ADDR);
   localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_ADDR);
   localparam logic [DATA_W-1:0] GO_VAL = DATA_W'(1);

   logic [ADDR_W-1:0] offset;
   logic              buf_hit;

   assign offset    = bus_addr - BASE_A;
   assign buf_hit   = (bus_addr >= BASE_A) && (offset < SPAN_A);
   assign buf_raddr = offset[BUF_AW-1:0];
   assign start     = bus_wr && (bus_addr == CMD_A) && (bus_wdata == GO_VAL) && !busy;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bus_rdata <= '0;
      end else if (bus_rd && buf_hit) begin
         bus_rdata <= buf_rdata;
      end else if (bus_rd && (bus_addr == STAT_A)) begin
         bus_rdata <= DATA_W'(stat_bit);
      end else begin
         bus_rdata <= '0;
      end
   end

endmodule

// File: rtl/zbc_corrector.sv
module zbc_corrector #(
   parameter int ROWS      = 64,
   parameter int COLS      = 64,
   parameter int DARK_N    = 2,
   parameter int PIX_W     = 8,
   parameter int ADDR_W    = 16,
   parameter int BUF_BASE  = 'h8000,
   parameter int CMD_ADDR  = 'h9000,
   parameter int STAT_ADDR = 'h9001
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sen_valid,
   input  logic [PIX_W-1:0]  sen_data,
   output logic              sen_ready,
   input  logic              bus_rd,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [PIX_W-1:0]  bus_wdata,
   output logic [PIX_W-1:0]  bus_rdata
);
   localparam int BUF_AW    = $clog2(ROWS) + $clog2(COLS);
   localparam int BUF_BYTES = ROWS * COLS;

   if ((ROWS < 2) || ((ROWS & (ROWS - 1)) != 0)) begin : g_bad_rows
      $error("ROWS must be a power of two of at least 2");
   end
   if ((COLS < 2) || ((COLS & (COLS - 1)) != 0)) begin : g_bad_cols
      $error("COLS must be a power of two of at least 2");
   end
   if ((DARK_N < 1) || ((DARK_N & (DARK_N - 1)) != 0)) begin : g_bad_dark
      $error("DARK_N must be a power of two");
   end
   if ((BUF_BASE + BUF_BYTES) > (1 << ADDR_W)) begin : g_bad_map
      $error("frame buffer does not fit the address space");
   end

   logic [DARK_N-1:0][PIX_W-1:0] dark_vec;
   logic [PIX_W-1:0]  bias_est, bias_use, fix_pix, fix_corr;
   logic [BUF_AW-1:0] fix_addr, mem_addr, buf_raddr;
   logic [PIX_W-1:0]  mem_wdata, buf_rdata;
   logic              mem_we, busy, frame_done, start;
   logic              valid_q, stat_bit;
   logic [PIX_W-1:0]  frame_mem [BUF_BYTES];

   always_ff @(posedge clk) begin
      if (mem_we) frame_mem[mem_addr] <= mem_wdata;
   end
   assign fix_pix   = frame_mem[fix_addr];
   assign buf_rdata = frame_mem[buf_raddr];

   always_ff @(posedge clk) begin
      if (!rst_n)          valid_q <= 1'b0;
      else if (start)      valid_q <= 1'b0;
      else if (frame_done) valid_q <= 1'b1;
   end
   assign stat_bit = valid_q && !busy;

   zbc_row_ctrl #(
      .ROWS(ROWS), .COLS(COLS), .DARK_N(DARK_N), .PIX_W(PIX_W)
   ) u_ctrl (
      .clk(clk), .rst_n(rst_n), .start(start),
      .sen_valid(sen_valid), .sen_data(sen_data), .sen_ready(sen_ready),
      .dark_vec(dark_vec), .bias_est(bias_est), .bias_use(bias_use),
      .corr_in(fix_corr), .fix_addr(fix_addr),
      .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .busy(busy), .frame_done(frame_done)
   );

   zbc_bias_unit #(.PIX_W(PIX_W), .DARK_N(DARK_N)) u_bias (
      .dark_vec(dark_vec), .bias_est(bias_est),
      .pix(fix_pix), .bias_use(bias_use), .corr(fix_corr)
   );

   zbc_bus_port #(
      .ADDR_W(ADDR_W), .DATA_W(PIX_W), .BUF_AW(BUF_AW), .BUF_BYTES(BUF_BYTES),
      .BUF_BASE(BUF_BASE), .CMD_ADDR(CMD_ADDR), .STAT_ADDR(STAT_ADDR)
   ) u_bus (
      .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .buf_raddr(buf_raddr), .buf_rdata(buf_rdata), .stat_bit(stat_bit),
      .busy(busy), .start(start)
   );

endmodule

// File: rtl/zbc_checker.sv
module zbc_checker #(
   parameter int ROW_BYTES = 66,
   parameter int PIX_W     = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             bus_rd,
   input logic [PIX_W-1:0] bus_rdata,
   input logic             sen_valid,
   input logic             sen_ready,
   input logic             busy,
   input logic             start,
   input logic             stat_bit,
   input logic [PIX_W-1:0] pix,
   input logic [PIX_W-1:0] corr
);
   localparam int CW = $clog2(ROW_BYTES + 1);
   logic [CW-1:0] acc_cnt;
   logic          last_byte;

   assign last_byte = sen_valid && sen_ready && (acc_cnt == CW'(ROW_BYTES - 1));

   always_ff @(posedge clk) begin
      if (!rst_n)                      acc_cnt <= '0;
      else if (last_byte)              acc_cnt <= '0;
      else if (sen_valid && sen_ready) acc_cnt <= acc_cnt + 1'b1;
   end

   a_r3_row_len: assert property (@(posedge clk) disable iff (!rst_n)
      last_byte |=> !sen_ready);

   a_r6_rdata_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(bus_rd) |-> (bus_rdata == '0));

   a_r2_busy_from_start: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(start));

   a_r7_status_after_frame: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stat_bit) |-> $past(busy));

   a_r5_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      corr <= pix);

endmodule

bind zbc_corrector zbc_checker #(
   .ROW_BYTES(DARK_N + COLS), .PIX_W(PIX_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
   .sen_valid(sen_valid), .sen_ready(sen_ready), .busy(busy), .start(start),
   .stat_bit(stat_bit), .pix(fix_pix), .corr(fix_corr)
);

// File: tb/sim_zbc_corrector.sv
module sim_zbc_corrector;
   localparam int BASE = 'h8000;
   localparam int CMD  = 'h9000;
   localparam int STAT = 'h9001;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sen_valid = 1'b0;
   logic [7:0]  sen_data = '0;
   logic        sen_ready;
   logic        bus_rd = 1'b0;
   logic        bus_wr = 1'b0;
   logic [15:0] bus_addr = '0;
   logic [7:0]  bus_wdata = '0;
   logic [7:0]  bus_rdata;

   int n_chk = 0;
   int n_bad = 0;

   always #2 clk = ~clk;

   zbc_corrector u0 (
      .clk(clk), .rst_n(rst_n), .sen_valid(sen_valid), .sen_data(sen_data),
      .sen_ready(sen_ready), .bus_rd(bus_rd), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic int dark_of(input int img, input int r, input int k);
      if (img == 0) return (r * 5 + k * 11 + 3) & 63;
      if (r == 3) return 255;
      if (r == 5) return (k == 0) ? 0 : 1;
      return (r * 13 + k * 29) & 127;
   endfunction

   function automatic int pix_of(input int img, input int r, input int c);
      if (img == 0) return (r * 7 + c * 3) & 255;
      return (r * c + 17 * c + r) & 255;
   endfunction

   function automatic int bias_of(input int img, input int r);
      return (dark_of(img, r, 0) + dark_of(img, r, 1)) >> 1;
   endfunction

   function automatic int exp_of(input int img, input int r, input int c);
      int p = pix_of(img, r, c);
      int b = bias_of(img, r);
      return (p > b) ? p - b : 0;
   endfunction

   task automatic bus_write(input int a, input int d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = 16'(a); bus_wdata = 8'(d);
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic bus_read(input int a, input bit chk_quiet, output int d);
      @(negedge clk);
      bus_rd = 1'b1; bus_addr = 16'(a);
      @(negedge clk);
      bus_rd = 1'b0;
      d = int'(bus_rdata);
      if (chk_quiet) begin
         @(negedge clk);
         check(bus_rdata == 8'd0, "R6", "rdata after read cycle", int'(bus_rdata), 0);
      end
   endtask

   task automatic feed_row(input int img, input int r);
      for (int k = 0; k < 66; k++) begin
         if ((k % 7) == 3) begin
            @(negedge clk);
            sen_valid = 1'b0;
         end
         @(negedge clk);
         sen_valid = 1'b1;
         sen_data  = (k < 2) ? 8'(dark_of(img, r, k)) : 8'(pix_of(img, r, k - 2));
         while (!sen_ready) @(negedge clk);
      end
      @(negedge clk);
      sen_valid = 1'b0;
      check(!sen_ready, "R10", "ready after last byte of row", int'(sen_ready), 0);
   endtask

   task automatic wait_status(output bit seen);
      int d;
      seen = 1'b0;
      for (int i = 0; i < 400 && !seen; i++) begin
         bus_read(STAT, 1'b0, d);
         if ((d & 1) == 1) seen = 1'b1;
      end
   endtask

   task automatic read_frame(input int img);
      int d;
      int e;
      for (int r = 0; r < 64; r++) begin
         for (int c = 0; c < 64; c++) begin
            bus_read(BASE + r * 64 + c, (r == 0 && c < 4), d);
            e = exp_of(img, r, c);
            check(d == e, (pix_of(img, r, c) <= bias_of(img, r)) ? "R5" : "R4",
                  $sformatf("pixel r%0d c%0d", r, c), d, e);
         end
      end
   endtask

   task automatic t_reset;
      int d;
      check(!sen_ready, "R1", "ready after reset", int'(sen_ready), 0);
      bus_read(STAT, 1'b1, d);
      check(d == 0, "R1", "status after reset", d, 0);
   endtask

   task automatic t_capture(input int img, input bit poke_busy);
      int d;
      bit seen;
      bus_write(CMD, 1);
      check(sen_ready, "R2", "ready after start", int'(sen_ready), 1);
      for (int r = 0; r < 64; r++) begin
         feed_row(img, r);
         if (r == 9) begin
            bus_read(STAT, 1'b0, d);
            check(d == 0, "R7", "status while busy", d, 0);
            if (poke_busy) begin
               bus_write(CMD, 1);   // R9: restart attempt mid-frame
            end
         end
      end
      wait_status(seen);
      check(seen, poke_busy ? "R9" : "R7", "status after frame", int'(seen), 1);
      read_frame(img);
   endtask

   task automatic t_corners(input int img);
      int d;
      bus_read(BASE, 1'b0, d);
      check(d == exp_of(img, 0, 0), "R8", "row 0 col 0", d, exp_of(img, 0, 0));
      bus_read(BASE + 63, 1'b0, d);
      check(d == exp_of(img, 0, 63), "R8", "row 0 col 63", d, exp_of(img, 0, 63));
      bus_read(BASE + 64, 1'b0, d);
      check(d == exp_of(img, 1, 0), "R8", "row 1 col 0", d, exp_of(img, 1, 0));
      bus_read(BASE + 4095, 1'b0, d);
      check(d == exp_of(img, 63, 63), "R8", "row 63 col 63", d, exp_of(img, 63, 63));
   endtask

   task automatic t_ignored;
      int d;
      bus_write(CMD, 2);
      check(!sen_ready, "R2", "ready after write of 2", int'(sen_ready), 0);
      bus_write(STAT, 1);
      check(!sen_ready, "R2", "ready after write to status", int'(sen_ready), 0);
      bus_read(STAT, 1'b0, d);
      check(d == 1, "R7", "status kept after ignored writes", d, 1);
      bus_read('h1234, 1'b1, d);
      check(d == 0, "R6", "unmapped read", d, 0);
      bus_read(BASE + 4096, 1'b0, d);
      check(d == 0, "R6", "read just past buffer", d, 0);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_capture(0, 1'b0);
      t_corners(0);
      t_ignored();
      t_capture(1, 1'b1);
      t_corners(1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (180000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule